// File: doc/BRIEF.md
# CAN Controller Reset and Initialization Sequencer

This block decides when the register file of a CAN protocol engine is forced back to its initial values, and when the engine may start taking part in bus traffic again. Software asks for a reset by setting a protected bit in the control register. The request only takes effect after a short unlock sequence. It then waits for the engine to reach a clean boundary: no frame in progress, or an error has just been flagged. At that point it clears the configuration state, strobes a clear to the engine's other registers and error counters, and puts the engine into software-init mode.

Normal operation resumes in two steps. First, software releases the reset through another unlocked write. Second, software drops the software-init flag. The engine then has to see a run of recessive bits on the bus before it is allowed to run. While the software-init flag is still set after release, configuration writes go through at once, so the engine can be set up during the idle wait or before it starts.

The control register at address 1 uses these bits: bit 0 is the software-init flag, bit 1 is power-down, bit 2 is sleep and bit 3 is the reset bit. Address 0 is the unlock register. Address 2 is a configuration register.

Top module: `can_rst_seq`

## Requirements
- R1: An unlock needs 0xAA and then 0x55 written to address 0 as two consecutive writes, with no other write between them. After that, one write to address 1 in any of the next 4 clock cycles may change bit 3. A write to address 1 made outside this window leaves bit 3 unchanged, and each unlock serves a single such write.
- R2: A pending reset engages only in a cycle where `busy_i` is low or `err_i` is high. While `busy_i` stays high and `err_i` stays low, the reset stays pending.
- R3: Bit 3 of the control register reads 0 while a reset is pending and not yet engaged. It reads 1 once the reset has engaged, and `rst_engaged_o` follows it.
- R4: When the reset engages, the control register reads 0x09 and the configuration register reads 0x00. `clr_o` is high for exactly one cycle.
- R5: Only an unlocked write with bit 3 = 0 releases an engaged reset or cancels a pending one. While engaged, writes to the other control bits are ignored unless they come with that release write. An unlocked write of bit 3 = 0 when no reset is pending or engaged has no effect on reset state and gives no `clr_o` pulse.
- R6: The configuration register accepts writes only while bit 0 of the control register is 1. This includes the cycles right after a release that keeps bit 0 at 1. Writes made while bit 0 is 0 are ignored.
- R7: When bit 0 goes to 0 with no reset engaged and `bus_off_i` low, a power-up wait starts. `run_o` rises only after 11 consecutive recessive samples (`bus_bit_i` = 1, counted on `bit_stb_i` only). A dominant sample restarts the count.
- R8: If `bus_off_i` is high when bit 0 goes to 0, the power-up wait does not count bits until `bus_off_i` falls.
- R9: `low_power_o` is high while bit 1 or bit 2 of the control register is 1. It stays high until both bits are 0.
- R10: After `rst_ni` the control register reads 0x01, the configuration register reads 0x00, and `rst_engaged_o`, `run_o` and `low_power_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| busy_i | input | 1 | Engine is transmitting or receiving a frame |
| err_i | input | 1 | Engine flagged an error condition |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| bit_stb_i | input | 1 | Bit sample strobe |
| bus_off_i | input | 1 | Engine is bus-off |
| rst_engaged_o | output | 1 | Reset is in effect |
| swinit_o | output | 1 | Software-init flag |
| clr_o | output | 1 | One-cycle clear for engine registers and error counters |
| run_o | output | 1 | Engine may operate normally |
| low_power_o | output | 1 | Engine held in low power |

## Verification
If the unlock state is wrong, an unprotected write engages or drops a reset. This shows on control bit 3 and on `clr_o` within two cycles of the control write. A wrong pending or engaged flag shows as bit 3 reading 1 before the safe point, or never reaching 1 after it. A power-up counter that miscounts, or that ignores a dominant sample, makes `run_o` rise on the wrong strobe. That is visible one cycle after the 11th recessive sample.

// File: rtl/can_rst_pkg.sv
package can_rst_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADDR_TA   = 2'd0;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd1;
  localparam logic [AW-1:0] ADDR_CFG  = 2'd2;

  localparam int unsigned SWI_BIT = 0;
  localparam int unsigned PD_BIT  = 1;
  localparam int unsigned SLP_BIT = 2;
  localparam int unsigned RST_BIT = 3;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_HOLD,
    ST_PWRUP,
    ST_RUN
  } seq_st_e;
endpackage

// File: rtl/can_ta_gate.sv
module can_ta_gate
  import can_rst_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned TA_WINDOW = 4,
  parameter logic [DW-1:0] KEY1    = 8'hAA,
  parameter logic [DW-1:0] KEY2    = 8'h55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          unlocked_o
);
  localparam int unsigned CW = $clog2(TA_WINDOW + 1);

  logic          stage1_q;
  logic [CW-1:0] win_q;

  wire ta_wr   = wr_en_i && (wr_addr_i == ADDR_TA);
  wire ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  assign unlocked_o = (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      win_q    <= '0;
    end else begin
      if (wr_en_i) stage1_q <= ta_wr && (wr_data_i == KEY1);
      if (ta_wr && stage1_q && (wr_data_i == KEY2))
        win_q <= CW'(TA_WINDOW);
      else if (ctrl_wr)
        win_q <= '0;  // one protected write per unlock
      else if (win_q != '0)
        win_q <= win_q - 1'b1;
    end
  end

  a_r1_unlock_from_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(ta_wr && wr_data_i == KEY2));
  a_r1_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= CW'(TA_WINDOW));
  a_r1_ctrl_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !unlocked_o);
endmodule

// File: rtl/can_idle_det.sv
module can_idle_det #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  input  logic stb_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(IDLE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (stb_i && !bit_i)   cnt_q <= '0;
    else if (stb_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  a_r7_dominant_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stb_i && !bit_i) |=> (cnt_q == '0));
  a_r7_no_count_without_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stb_i && $past(en_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/can_rst_fsm.sv
module can_rst_fsm
  import can_rst_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter logic [DW-1:0] CTRL_RST   = 8'h09,
  parameter logic [DW-1:0] CTRL_POR   = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          unlocked_i,
  input  logic          busy_i,
  input  logic          err_i,
  input  logic          bus_off_i,
  input  logic          idle_done_i,
  output logic          engaged_o,
  output logic [DW-1:0] ctrl_rd_o,
  output logic [DW-1:0] cfg_o,
  output logic          clr_o,
  output logic          swinit_o,
  output logic          pwrup_o,
  output logic          run_o,
  output logic          low_power_o
);
  localparam logic [DW-1:0] RST_MASK = DW'(1) << RST_BIT;

  logic          engaged_q, pending_q, clr_q;
  logic [DW-1:0] ctrl_q, cfg_q;
  seq_st_e       st_q;

  wire prot_wr = ctrl_wr_i && unlocked_i;
  wire cancel  = prot_wr && !wr_data_i[RST_BIT];
  wire safe    = !busy_i || err_i;
  wire engage  = pending_q && safe && !cancel;
  wire release_wr = cancel && engaged_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      engaged_q <= 1'b0;
      pending_q <= 1'b0;
      clr_q     <= 1'b0;
      ctrl_q    <= CTRL_POR & ~RST_MASK;
      cfg_q     <= '0;
    end else begin
      clr_q <= engage;
      if (engage) begin
        engaged_q <= 1'b1;
        pending_q <= 1'b0;
        ctrl_q    <= CTRL_RST & ~RST_MASK;
        cfg_q     <= '0;
      end else begin
        if (prot_wr) begin
          if (wr_data_i[RST_BIT]) begin
            if (!engaged_q) pending_q <= 1'b1;
          end else begin
            pending_q <= 1'b0;
            engaged_q <= 1'b0;
          end
        end
        if (ctrl_wr_i && (!engaged_q || release_wr))
          ctrl_q <= wr_data_i & ~RST_MASK;
        if (cfg_wr_i && ctrl_q[SWI_BIT])
          cfg_q <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INIT;
    else if (engaged_q || ctrl_q[SWI_BIT]) st_q <= ST_INIT;
    else begin
      unique case (st_q)
        ST_INIT:  st_q <= bus_off_i ? ST_HOLD : ST_PWRUP;
        ST_HOLD:  if (!bus_off_i) st_q <= ST_PWRUP;
        ST_PWRUP: if (idle_done_i) st_q <= ST_RUN;
        ST_RUN:   st_q <= ST_RUN;
        default:  st_q <= ST_INIT;
      endcase
    end
  end

  assign engaged_o   = engaged_q;
  assign ctrl_rd_o   = ctrl_q | (engaged_q ? RST_MASK : '0);
  assign cfg_o       = cfg_q;
  assign clr_o       = clr_q;
  assign swinit_o    = ctrl_q[SWI_BIT];
  assign pwrup_o     = (st_q == ST_PWRUP);
  assign run_o       = (st_q == ST_RUN);
  assign low_power_o = ctrl_q[PD_BIT] | ctrl_q[SLP_BIT];

  a_r2_engage_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(engaged_q) |-> $past(!busy_i || err_i));
  a_r3_engage_after_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(engaged_q) |-> $past(pending_q));
  a_r4_cfg_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(engaged_q) |-> (cfg_q == '0) && clr_q);
  a_r5_no_pending_when_engaged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engaged_q |-> !pending_q);
  a_r7_no_run_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[SWI_BIT] || engaged_q) |=> (st_q != ST_RUN));
  a_r8_hold_while_bus_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && bus_off_i && !ctrl_q[SWI_BIT] && !engaged_q) |=> (st_q == ST_HOLD));
endmodule

// File: rtl/can_rst_seq.sv
module can_rst_seq
  import can_rst_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned TA_WINDOW = 4,
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          busy_i,
  input  logic          err_i,
  input  logic          bus_bit_i,
  input  logic          bit_stb_i,
  input  logic          bus_off_i,
  output logic          rst_engaged_o,
  output logic          swinit_o,
  output logic          clr_o,
  output logic          run_o,
  output logic          low_power_o
);
  logic          unlocked, idle_done, pwrup;
  logic [DW-1:0] ctrl_rd, cfg;

  can_ta_gate #(.DW(DW), .TA_WINDOW(TA_WINDOW)) u_ta (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .unlocked_o (unlocked)
  );

  can_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni,
    .en_i   (pwrup),
    .bit_i  (bus_bit_i),
    .stb_i  (bit_stb_i),
    .done_o (idle_done)
  );

  can_rst_fsm #(.DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .ctrl_wr_i   (wr_en_i && wr_addr_i == ADDR_CTRL),
    .cfg_wr_i    (wr_en_i && wr_addr_i == ADDR_CFG),
    .wr_data_i,
    .unlocked_i  (unlocked),
    .busy_i, .err_i, .bus_off_i,
    .idle_done_i (idle_done),
    .engaged_o   (rst_engaged_o),
    .ctrl_rd_o   (ctrl_rd),
    .cfg_o       (cfg),
    .clr_o,
    .swinit_o,
    .pwrup_o     (pwrup),
    .run_o,
    .low_power_o
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = ctrl_rd;
      ADDR_CFG:  rd_data_o = cfg;
      default:   rd_data_o = '0;
    endcase
  end

  a_r7_run_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(idle_done));
  a_r3_readback_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_CTRL) |-> (rd_data_o[RST_BIT] == rst_engaged_o));
endmodule

// File: tb/sim_can_rst_seq.sv
module sim_can_rst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy = 1'b0, err = 1'b0, bus_bit = 1'b1, bit_stb = 1'b0, bus_off = 1'b0;
  logic engaged, swinit, clr, run, low_power;

  int checks = 0;
  int errors = 0;
  int clr_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  can_rst_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_i(busy), .err_i(err), .bus_bit_i(bus_bit), .bit_stb_i(bit_stb),
    .bus_off_i(bus_off), .rst_engaged_o(engaged), .swinit_o(swinit),
    .clr_o(clr), .run_o(run), .low_power_o(low_power)
  );

  always @(negedge clk) if (clr) clr_cnt++;

  // {key1, key2, idle cycles before control write, expect engaged}
  localparam logic [19:0] TV [0:5] = '{
    {8'hAA, 8'h55, 3'd0, 1'b1},
    {8'hAA, 8'h55, 3'd3, 1'b1},
    {8'hAA, 8'h55, 3'd4, 1'b0},
    {8'h55, 8'hAA, 3'd0, 1'b0},
    {8'hAA, 8'hAA, 3'd0, 1'b0},
    {8'hAB, 8'h55, 3'd0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd0, 8'hAA);
    wr(2'd0, 8'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      bus_bit = b; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] d;
    int c0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    rd(2'd1, d); chk("R10 ctrl", d, 8'h01);
    rd(2'd2, d); chk("R10 cfg", d, 8'h00);
    chk("R10 engaged", engaged, 0);
    chk("R10 run", run, 0);
    chk("R10 low_power", low_power, 0);

    // R1 unlock sequences
    for (int i = 0; i < 6; i++) begin
      logic [19:0] v;
      v = TV[i];
      wr(2'd0, v[19:12]);
      wr(2'd0, v[11:4]);
      idle(int'(v[3:1]));
      wr(2'd1, 8'h09);
      idle(2);
      rd(2'd1, d);
      chk($sformatf("R1 vector %0d bit3", i), d[3], v[0]);
      if (v[0]) begin
        unlock();
        wr(2'd1, 8'h01);
        idle(1);
      end
    end
    rd(2'd1, d); chk("R1 ctrl after vectors", d, 8'h01);

    // R6 cfg writable in init mode
    wr(2'd2, 8'h5A);
    rd(2'd2, d); chk("R6 cfg write in init", d, 8'h5A);

    // R2/R3 deferral while busy, engage on error
    busy = 1'b1;
    unlock();
    wr(2'd1, 8'h09);
    idle(5);
    rd(2'd1, d); chk("R3 pending reads 0", d[3], 0);
    chk("R2 not engaged while busy", engaged, 0);
    c0 = clr_cnt;
    err = 1'b1; idle(1); err = 1'b0;
    idle(1);
    chk("R2 engaged on error", engaged, 1);
    rd(2'd1, d); chk("R4 ctrl 0x09", d, 8'h09);
    rd(2'd2, d); chk("R4 cfg cleared", d, 8'h00);
    chk("R4 single clr pulse", clr_cnt - c0, 1);

    // R5 release rules
    wr(2'd1, 8'h00);
    idle(1);
    rd(2'd1, d); chk("R5 plain write ignored when engaged", d, 8'h09);
    unlock();
    wr(2'd1, 8'h01);
    idle(1);
    rd(2'd1, d); chk("R5 release keeps init", d, 8'h01);
    chk("R5 released", engaged, 0);
    // R6 writable right after release
    wr(2'd2, 8'h3C);
    rd(2'd2, d); chk("R6 cfg after release", d, 8'h3C);

    // R2 engage when busy falls, then release
    unlock();
    wr(2'd1, 8'h09);
    idle(3);
    chk("R2 waits for busy", engaged, 0);
    busy = 1'b0;
    idle(2);
    chk("R2 engaged after busy low", engaged, 1);
    unlock(); wr(2'd1, 8'h01); idle(1);

    // R5 cancel pending, and write of 0 when idle
    busy = 1'b1;
    unlock(); wr(2'd1, 8'h09);
    unlock(); wr(2'd1, 8'h01);
    c0 = clr_cnt;
    busy = 1'b0;
    idle(4);
    chk("R5 cancel pending", engaged, 0);
    unlock(); wr(2'd1, 8'h01); idle(3);
    chk("R5 zero write no effect", engaged, 0);
    chk("R5 no clr pulse", clr_cnt - c0, 0);

    // R6 cfg ignored outside init
    wr(2'd2, 8'h3C);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h77);
    rd(2'd2, d); chk("R6 cfg ignored when swinit 0", d, 8'h3C);

    // R7 power-up idle run
    idle(1);
    strobe(1'b1, 10);
    strobe(1'b0, 1);
    strobe(1'b1, 10);
    chk("R7 dominant restarts count", run, 0);
    strobe(1'b1, 1);
    chk("R7 run after 11 recessive", run, 1);

    // R8 bus-off holds power-up
    wr(2'd1, 8'h01);
    idle(1);
    chk("R7 init stops run", run, 0);
    bus_off = 1'b1;
    wr(2'd1, 8'h00);
    idle(1);
    strobe(1'b1, 15);
    chk("R8 held while bus-off", run, 0);
    bus_off = 1'b0;
    idle(2);
    strobe(1'b1, 10);
    chk("R8 still counting", run, 0);
    strobe(1'b1, 1);
    chk("R8 run after bus-off clears", run, 1);

    // R9 low power bits
    wr(2'd1, 8'h06); chk("R9 both set", low_power, 1);
    wr(2'd1, 8'h04); chk("R9 sleep only", low_power, 1);
    wr(2'd1, 8'h02); chk("R9 power-down only", low_power, 1);
    wr(2'd1, 8'h00); chk("R9 both clear", low_power, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule